// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This block is a 32-bit execution unit for a processor's shift and rotate operations. On each cycle it can accept one operation. An operation carries an operation code, a destination operand, a second source operand, two count inputs and the incoming carry flag. The second source operand is used only by the double-precision shifts. One count input is an immediate field and the other is a count-register value. One clock later the unit returns the shifted or rotated value and the updated carry flag.

The unit covers several families of operation:
- shifts left, which are the same in their logical and arithmetic forms;
- logical and arithmetic shifts right;
- plain rotates;
- rotates that pass through the carry flag, forming a 33-bit ring;
- double-precision shifts, which pull the vacated bits from the second source operand.

The carry output always holds the last bit that left the operand. An effective count of zero changes nothing.

Top module: `shrot_unit`

## Requirements
- R1: `out_valid` rises exactly one clock after a cycle with `in_valid` high. In a cycle with `in_valid` low, `out_valid` falls on the next clock, and `out_result` and `out_carry` keep their previous values.
- R2: The count is taken from `in_reg_cnt` when `in_cnt_sel` is 1 and from `in_imm_cnt` when it is 0. Only the low 5 bits of the selected count are used.
- R3: When the masked count is zero, the result equals `in_dst` and the carry equals `in_carry`. This holds for every operation code.
- R4: Codes 0 (logical left) and 1 (arithmetic left) give the same result. The operand moves left by the count, zeros enter at the bottom, and the carry is the last bit that left the top.
- R5: Code 2 (logical right) moves the operand right and fills zeros from the top. The carry is the last bit that left the bottom.
- R6: Code 3 (arithmetic right) moves the operand right and copies the original bit 31 into the vacated top bits. The carry is the last bit that left the bottom.
- R7: Code 4 (rotate left) and code 5 (rotate right) move the bits that leave one end into the other end. The carry equals the bit that wrapped last: result bit 0 for code 4 and result bit 31 for code 5.
- R8: Code 6 (rotate left through carry) and code 7 (rotate right through carry) rotate the 33-bit ring formed by the carry above bit 31. The count is taken modulo 33. The new carry is the ring's top position.
- R9: Code 8 (double left) shifts `in_dst` left and fills the low bits from the top bits of `in_src`. Code 9 (double right) shifts `in_dst` right and fills the high bits from the low bits of `in_src`. The carry is the last bit that left `in_dst`.
- R10: Codes 10 to 15 return `in_dst` unchanged and leave the carry unchanged.
- R11: While reset is held, and directly after it, `out_valid`, `out_result` and `out_carry` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 4 | Operation code |
| in_dst | input | 32 | Destination operand |
| in_src | input | 32 | Second source operand, used by the double shifts |
| in_imm_cnt | input | 8 | Immediate count field |
| in_reg_cnt | input | 8 | Count-register value |
| in_cnt_sel | input | 1 | 1 selects the count register, 0 selects the immediate |
| in_carry | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result is valid |
| out_result | output | 32 | Shifted or rotated value |
| out_carry | output | 1 | Updated carry flag |

## Verification
The hardest case to reach from the ports is a count that is non-zero as a full byte but zero after masking, such as 32, 64 or 224. Such a count must leave both the operand and the carry untouched. It must do so even for the rotates through carry, where a careless modulo or a 6-bit count would rotate the ring. The stimulus drives these byte values on the selected count input. At the same time it drives a large, non-zero count on the input that is not selected, so that a wrong select or a missing mask shows up. A random sweep then covers every code, both carry values and every count from 0 to 255. All of it is checked against a model that moves one bit per step.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    typedef enum logic [3:0] {
        OP_SHL  = 4'd0,
        OP_SAL  = 4'd1,
        OP_SHR  = 4'd2,
        OP_SAR  = 4'd3,
        OP_ROL  = 4'd4,
        OP_ROR  = 4'd5,
        OP_RCL  = 4'd6,
        OP_RCR  = 4'd7,
        OP_DSHL = 4'd8,
        OP_DSHR = 4'd9
    } shrot_op_e;

endpackage

// File: rtl/shrot_count_sel.sv
module shrot_count_sel #(
    parameter int CNT_W = 8,
    parameter int SH_W  = 5
) (
    input  logic [CNT_W-1:0] imm_cnt,
    input  logic [CNT_W-1:0] reg_cnt,
    input  logic             use_reg,
    output logic [SH_W-1:0]  eff_cnt
);
    // Only the low SH_W bits of the chosen source take part.
    always_comb begin
        if (use_reg) begin
            eff_cnt = reg_cnt[SH_W-1:0];
        end else begin
            eff_cnt = imm_cnt[SH_W-1:0];
        end
    end
endmodule

// File: rtl/shrot_core.sv
module shrot_core
    import shrot_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int SH_W  = 5
) (
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] dst,
    input  logic [WIDTH-1:0] src,
    input  logic [SH_W-1:0]  cnt,
    input  logic             cin,
    output logic [WIDTH-1:0] res,
    output logic             cout
);
    localparam int RING_W = WIDTH + 1;
    localparam int DBL_W  = 2 * WIDTH;

    logic [WIDTH:0]        shl_ext;
    logic [WIDTH:0]        shr_ext;
    logic [WIDTH:0]        sar_ext;
    logic [DBL_W-1:0]      rotl_pair;
    logic [DBL_W-1:0]      rotr_pair;
    logic [RING_W-1:0]     ring;
    logic [2*RING_W-1:0]   rcl_pair;
    logic [2*RING_W-1:0]   rcr_pair;
    logic [SH_W:0]         ring_cnt;
    logic [DBL_W:0]        dshl_ext;
    logic [DBL_W:0]        dshr_ext;

    always_comb begin
        // One guard bit beside the operand catches the last bit shifted out.
        shl_ext   = {1'b0, dst} << cnt;
        shr_ext   = {dst, 1'b0} >> cnt;
        sar_ext   = $signed({dst, 1'b0}) >>> cnt;
        rotl_pair = {dst, dst} << cnt;
        rotr_pair = {dst, dst} >> cnt;
        ring      = {cin, dst};
        ring_cnt  = (SH_W+1)'(32'(cnt) % RING_W);
        rcl_pair  = {ring, ring} << ring_cnt;
        rcr_pair  = {ring, ring} >> ring_cnt;
        dshl_ext  = {1'b0, dst, src} << cnt;
        dshr_ext  = {src, dst, 1'b0} >> cnt;

        res  = dst;
        cout = cin;
        if (cnt != '0) begin
            case (op)
                OP_SHL, OP_SAL: begin
                    res  = shl_ext[WIDTH-1:0];
                    cout = shl_ext[WIDTH];
                end
                OP_SHR: begin
                    res  = shr_ext[WIDTH:1];
                    cout = shr_ext[0];
                end
                OP_SAR: begin
                    res  = sar_ext[WIDTH:1];
                    cout = sar_ext[0];
                end
                OP_ROL: begin
                    res  = rotl_pair[DBL_W-1:WIDTH];
                    cout = rotl_pair[WIDTH];
                end
                OP_ROR: begin
                    res  = rotr_pair[WIDTH-1:0];
                    cout = rotr_pair[WIDTH-1];
                end
                OP_RCL: begin
                    res  = rcl_pair[2*RING_W-2:RING_W];
                    cout = rcl_pair[2*RING_W-1];
                end
                OP_RCR: begin
                    res  = rcr_pair[WIDTH-1:0];
                    cout = rcr_pair[RING_W-1];
                end
                OP_DSHL: begin
                    res  = dshl_ext[DBL_W-1:WIDTH];
                    cout = dshl_ext[DBL_W];
                end
                OP_DSHR: begin
                    res  = dshr_ext[WIDTH:1];
                    cout = dshr_ext[0];
                end
                default: begin
                    res  = dst;
                    cout = cin;
                end
            endcase
        end
    end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit #(
    parameter int WIDTH = 32,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [3:0]       in_op,
    input  logic [WIDTH-1:0] in_dst,
    input  logic [WIDTH-1:0] in_src,
    input  logic [CNT_W-1:0] in_imm_cnt,
    input  logic [CNT_W-1:0] in_reg_cnt,
    input  logic             in_cnt_sel,
    input  logic             in_carry,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_result,
    output logic             out_carry
);
    localparam int SH_W = $clog2(WIDTH);

    typedef struct packed {
        logic             valid;
        logic [WIDTH-1:0] result;
        logic             carry;
    } out_state_t;

    out_state_t        st_d;
    out_state_t        st_q;
    logic [SH_W-1:0]   cnt_w;
    logic [WIDTH-1:0]  core_res;
    logic              core_cout;

    shrot_count_sel #(
        .CNT_W (CNT_W),
        .SH_W  (SH_W)
    ) u_cnt (
        .imm_cnt (in_imm_cnt),
        .reg_cnt (in_reg_cnt),
        .use_reg (in_cnt_sel),
        .eff_cnt (cnt_w)
    );

    shrot_core #(
        .WIDTH (WIDTH),
        .SH_W  (SH_W)
    ) u_core (
        .op   (in_op),
        .dst  (in_dst),
        .src  (in_src),
        .cnt  (cnt_w),
        .cin  (in_carry),
        .res  (core_res),
        .cout (core_cout)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.result = core_res;
            st_d.carry  = core_cout;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign out_result = st_q.result;
    assign out_carry  = st_q.carry;
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
    parameter int WIDTH = 32,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [3:0]       in_op,
    input logic [WIDTH-1:0] in_dst,
    input logic [CNT_W-1:0] in_imm_cnt,
    input logic [CNT_W-1:0] in_reg_cnt,
    input logic             in_cnt_sel,
    input logic             in_carry,
    input logic             out_valid,
    input logic [WIDTH-1:0] out_result,
    input logic             out_carry
);
    localparam int SH_W = $clog2(WIDTH);

    logic [SH_W-1:0] chk_cnt;
    assign chk_cnt = in_cnt_sel ? in_reg_cnt[SH_W-1:0] : in_imm_cnt[SH_W-1:0];

    // R1
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_carry)));
    // R3
    a_r3_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && chk_cnt == '0) |=>
        (out_result == $past(in_dst) && out_carry == $past(in_carry)));
    // R4
    a_r4_low_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op <= 4'd1 && chk_cnt != '0) |=> !out_result[0]);
    // R5
    a_r5_high_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'd2 && chk_cnt != '0) |=> !out_result[WIDTH-1]);
    // R6
    a_r6_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'd3) |=> out_result[WIDTH-1] == $past(in_dst[WIDTH-1]));
    // R7
    a_r7_rotate_keeps_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == 4'd4 || in_op == 4'd5)) |=>
        $countones(out_result) == $countones($past(in_dst)));
    // R8
    a_r8_ring_keeps_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == 4'd6 || in_op == 4'd7)) |=>
        $countones({out_carry, out_result}) == $countones($past({in_carry, in_dst})));
    // R10
    a_r10_undefined_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op >= 4'd10) |=>
        (out_result == $past(in_dst) && out_carry == $past(in_carry)));
endmodule

bind shrot_unit shrot_unit_chk #(
    .WIDTH (WIDTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_dst     (in_dst),
    .in_imm_cnt (in_imm_cnt),
    .in_reg_cnt (in_reg_cnt),
    .in_cnt_sel (in_cnt_sel),
    .in_carry   (in_carry),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_carry  (out_carry)
);

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic [31:0] in_dst = '0;
    logic [31:0] in_src = '0;
    logic [7:0]  in_imm_cnt = '0;
    logic [7:0]  in_reg_cnt = '0;
    logic        in_cnt_sel = 1'b0;
    logic        in_carry = 1'b0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_carry;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state: what the outputs must show after the next edge.
    logic        m_valid = 1'b0;
    logic [31:0] m_res = '0;
    logic        m_carry = 1'b0;

    always #2 clk = ~clk;

    shrot_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_op      (in_op),
        .in_dst     (in_dst),
        .in_src     (in_src),
        .in_imm_cnt (in_imm_cnt),
        .in_reg_cnt (in_reg_cnt),
        .in_cnt_sel (in_cnt_sel),
        .in_carry   (in_carry),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_carry  (out_carry)
    );

    function automatic string op_tag(input logic [3:0] op, input int cnt);
        if (cnt == 0) return "R3";
        case (op)
            4'd0, 4'd1: return "R4";
            4'd2:       return "R5";
            4'd3:       return "R6";
            4'd4, 4'd5: return "R7";
            4'd6, 4'd7: return "R8";
            4'd8, 4'd9: return "R9";
            default:    return "R10";
        endcase
    endfunction

    // Moves one bit per step, count times.
    task automatic model_op(input logic [3:0] op, input logic [31:0] d, input logic [31:0] s,
                            input int cnt, input logic cin);
        logic [31:0] v = d;
        logic [31:0] w = s;
        logic        c = cin;
        logic        t;
        int          n = (op == 4'd6 || op == 4'd7) ? (cnt % 33) : cnt;
        if (op <= 4'd9) begin
            for (int i = 0; i < n; i++) begin
                case (op)
                    4'd0, 4'd1: begin c = v[31]; v = v << 1; end
                    4'd2:       begin c = v[0];  v = v >> 1; end
                    4'd3:       begin c = v[0];  v = {v[31], v[31:1]}; end
                    4'd4:       begin c = v[31]; v = {v[30:0], v[31]}; end
                    4'd5:       begin c = v[0];  v = {v[0], v[31:1]}; end
                    4'd6:       begin t = v[31]; v = {v[30:0], c}; c = t; end
                    4'd7:       begin t = v[0];  v = {c, v[31:1]}; c = t; end
                    4'd8:       begin c = v[31]; v = {v[30:0], w[31]}; w = w << 1; end
                    default:    begin c = v[0];  v = {w[0], v[31:1]}; w = w >> 1; end
                endcase
            end
        end
        m_res   = v;
        m_carry = c;
    endtask

    task automatic compare(input string tag);
        checks++;
        if (out_valid !== m_valid || out_result !== m_res || out_carry !== m_carry) begin
            errors++;
            $display("FAIL %s: actual valid=%0b res=%08h carry=%0b expected valid=%0b res=%08h carry=%0b",
                     tag, out_valid, out_result, out_carry, m_valid, m_res, m_carry);
        end
    endtask

    task automatic issue(input string tag, input logic [3:0] op, input logic [31:0] d,
                         input logic [31:0] s, input logic [7:0] imm, input logic [7:0] rc,
                         input logic sel, input logic cin);
        int cnt;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_dst = d; in_src = s;
        in_imm_cnt = imm; in_reg_cnt = rc; in_cnt_sel = sel; in_carry = cin;
        cnt = sel ? int'(rc[4:0]) : int'(imm[4:0]);
        m_valid = 1'b1;
        model_op(op, d, s, cnt, cin);
        @(posedge clk); #1;
        compare(tag.len() != 0 ? tag : op_tag(op, cnt));
    endtask

    // Idle cycle with noisy inputs: outputs must not move (R1).
    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; in_op = 4'($urandom); in_dst = $urandom; in_src = $urandom;
        in_imm_cnt = 8'($urandom); in_reg_cnt = 8'($urandom); in_carry = 1'($urandom);
        m_valid = 1'b0;
        @(posedge clk); #1;
        compare("R1");
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        compare("R11");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        compare("R11");

        // R4 left shifts, both codes
        issue("R4", 4'd0, 32'h8000_0001, 32'h0, 8'd1, 8'd0, 1'b0, 1'b0);
        issue("R4", 4'd1, 32'h1234_5678, 32'h0, 8'd4, 8'd0, 1'b0, 1'b1);
        issue("R4", 4'd0, 32'h0000_0001, 32'h0, 8'd31, 8'd0, 1'b0, 1'b0);
        // R5 logical right
        issue("R5", 4'd2, 32'h8000_0003, 32'h0, 8'd2, 8'd0, 1'b0, 1'b0);
        // R6 arithmetic right keeps sign
        issue("R6", 4'd3, 32'h8000_0000, 32'h0, 8'd4, 8'd0, 1'b0, 1'b1);
        issue("R6", 4'd3, 32'h7FFF_FFFF, 32'h0, 8'd31, 8'd0, 1'b0, 1'b0);
        // R7 rotates
        issue("R7", 4'd4, 32'h8000_0000, 32'h0, 8'd1, 8'd0, 1'b0, 1'b0);
        issue("R7", 4'd5, 32'h0000_0001, 32'h0, 8'd1, 8'd0, 1'b0, 1'b0);
        // R8 rotate through carry, carry in enters the ring
        issue("R8", 4'd6, 32'h0000_0000, 32'h0, 8'd1, 8'd0, 1'b0, 1'b1);
        issue("R8", 4'd7, 32'h0000_0001, 32'h0, 8'd31, 8'd0, 1'b0, 1'b1);
        // R9 double shifts feed from the second source
        issue("R9", 4'd8, 32'h0000_00FF, 32'hF000_0000, 8'd8, 8'd0, 1'b0, 1'b0);
        issue("R9", 4'd9, 32'hFFFF_0000, 32'h0000_000A, 8'd16, 8'd0, 1'b0, 1'b0);
        // R2 count source select and masking
        issue("R2", 4'd0, 32'h0000_0001, 32'h0, 8'd0, 8'd3, 1'b1, 1'b0);
        issue("R2", 4'd2, 32'hF000_0000, 32'h0, 8'd28, 8'd5, 1'b0, 1'b0);
        issue("R2", 4'd4, 32'h0000_0001, 32'h0, 8'hE1, 8'd17, 1'b0, 1'b0);
        // R3 masked zero counts leave operand and carry
        issue("R3", 4'd6, 32'hDEAD_BEEF, 32'h0, 8'd32, 8'd9, 1'b0, 1'b1);
        issue("R3", 4'd7, 32'h1357_9BDF, 32'h0, 8'd3, 8'd64, 1'b1, 1'b1);
        issue("R3", 4'd3, 32'h8000_0001, 32'h0, 8'd224, 8'd1, 1'b0, 1'b0);
        // R10 undefined codes pass through
        issue("R10", 4'd12, 32'hCAFE_F00D, 32'h0, 8'd7, 8'd0, 1'b0, 1'b1);
        issue("R10", 4'd15, 32'h0BAD_0BAD, 32'h0, 8'd1, 8'd0, 1'b0, 1'b0);
        // R1 idle holds the last value
        idle();
        idle();

        for (int k = 0; k < 3000; k++) begin
            if (($urandom % 5) == 0) begin
                idle();
            end else begin
                issue("", 4'($urandom), $urandom, $urandom, 8'($urandom), 8'($urandom),
                      1'($urandom), 1'($urandom));
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule